// File: doc/BRIEF.md
# Masked Interrupt Event Controller

This block collects the interrupt events of an Ethernet MAC into a 32-bit event register, qualifies them with a 32-bit mask register and drives thirteen dedicated interrupt request lines. Each line carries one event. The lines follow a fixed order that does not match the bit order of the event register. Internal logic raises events with single-cycle pulses. Software clears events by writing ones to the event register, and it programs the mask with a plain write. A write of bit 0 to the transmit-control address stands for a graceful-stop request, and it raises the graceful-stop event at once.

The register port is a write strobe with a 2-bit select and 32-bit data, and a separate read select that returns data combinationally. Select 0 addresses the event register and select 1 addresses the mask register. Select 2 addresses transmit control, and select 3 is reserved. An asynchronous active-low reset is released synchronously inside the block. A synchronous soft-reset input clears both registers.

Top module: `mic_irq_ctrl`

## Requirements
- R1: After reset the event register, the mask register and all 13 IRQ lines read zero.
- R2: A pulse on evt_set[k] sets event bit 19+k, and the bit stays set until software clears it. The event bits are: underrun 19, retry-limit 20, late-collision 21, bus-error 22, MII 23, rx-buffer 24, rx-frame 25, tx-buffer 26, tx-frame 27, graceful-stop 28, babbling-transmit 29, babbling-receive 30, heartbeat 31.
- R3: A write with select 0 clears every event bit that is 1 in the written data and leaves every other event bit unchanged.
- R4: A write with select 1 replaces all 32 mask bits with the written data.
- R5: IRQ line n carries event bit B[n], where B = {27,26,19,20,25,24,23,21,31,28,22,29,30} for n = 0 to 12.
- R6: irq[n] is high exactly when event bit B[n] and mask bit B[n] are both set. It updates on the clock edge after the one that changed either register bit.
- R7: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: A write with select 2 and data bit 0 equal to 1 sets event bit 28. The same write with bit 0 equal to 0 changes no event bit.
- R9: Soft reset clears both registers in one cycle, even against a simultaneous event pulse. The IRQ lines go low one cycle later.
- R10: Event bits 18 to 0 always read zero. Reads with select 2 or 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of both registers |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 event, 1 mask, 2 transmit control |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select |
| rd_data | output | 32 | Read data for rd_sel |
| evt_set | input | 13 | Event-set pulses; bit k sets event bit 19+k |
| irq | output | 13 | Registered interrupt request lines |

## Verification
The bench uses the default parameters: a 32-bit word, 13 events starting at bit 19, and 13 lines. This size is small enough that every line is swept on its own. Each line is checked once with its event alone under an all-ones mask, and once with every event set and a single mask bit open, which exposes any swap in the line order. Walking clear and mask patterns, set-against-clear collisions, graceful-stop writes and soft reset against live pulses are then compared with an arithmetic model of the two registers.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_EVT  = 13;
  localparam int EVT_LSB  = 19;
  localparam int NUM_LINE = 13;
  localparam int GS_BIT   = 28;

  typedef enum logic [1:0] {
    SEL_EVENT = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_TXCTL = 2'd2,
    SEL_RSVD  = 2'd3
  } reg_sel_e;

  // Event bit carried by each interrupt line
  function automatic int line_bit(input int line);
    case (line)
      0:       return 27;
      1:       return 26;
      2:       return 19;
      3:       return 20;
      4:       return 25;
      5:       return 24;
      6:       return 23;
      7:       return 21;
      8:       return 31;
      9:       return 28;
      10:      return 22;
      11:      return 29;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/mic_rst_sync.sv
module mic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/mic_event_reg.sv
module mic_event_reg #(
  parameter int W       = 32,
  parameter int NUM_EVT = 13,
  parameter int EVT_LSB = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic               clr_en,
  input  logic [W-1:0]       clr_bits,
  input  logic [NUM_EVT-1:0] set_vec,
  output logic [W-1:0]       ev_q
);
  localparam int EVT_MSB = EVT_LSB + NUM_EVT - 1;

  logic [W-1:0] set_full;
  logic [W-1:0] clr_full;
  logic [W-1:0] ev_d;
  logic         ev_en;

  // place set pulses at their event positions, zero elsewhere
  for (genvar b = 0; b < W; b++) begin : g_set
    if (b >= EVT_LSB && b <= EVT_MSB) begin : g_evt
      assign set_full[b] = set_vec[b-EVT_LSB];
    end else begin : g_none
      assign set_full[b] = 1'b0;
    end
  end

  assign clr_full = clr_en ? clr_bits : '0;

  always_comb begin
    if (soft_clr) ev_d = '0;
    else          ev_d = (ev_q & ~clr_full) | set_full;
  end

  assign ev_en = soft_clr | clr_en | (|set_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ev_q <= '0;
    else if (ev_en) ev_q <= ev_d;
  end
endmodule

// File: rtl/mic_mask_reg.sv
module mic_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] mask_d;
  logic         mask_en;

  always_comb begin
    if (soft_clr) mask_d = '0;
    else          mask_d = load_val;
  end

  assign mask_en = soft_clr | load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/mic_line_fanout.sv
module mic_line_fanout
  import mic_pkg::*;
#(
  parameter int W        = 32,
  parameter int NUM_LINE = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        ev,
  input  logic [W-1:0]        mask,
  output logic [NUM_LINE-1:0] irq_q
);
  logic [W-1:0]        active;
  logic [NUM_LINE-1:0] irq_d;
  logic                irq_en;

  assign active = ev & mask;

  for (genvar n = 0; n < NUM_LINE; n++) begin : g_line
    localparam int SRC = line_bit(n);
    assign irq_d[n] = active[SRC];
  end

  assign irq_en = |(irq_d ^ irq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= '0;
    else if (irq_en) irq_q <= irq_d;
  end
endmodule

// File: rtl/mic_irq_ctrl.sv
module mic_irq_ctrl
  import mic_pkg::*;
#(
  parameter int W        = WORD_W,
  parameter int NUM_E    = NUM_EVT,
  parameter int E_LSB    = EVT_LSB,
  parameter int NUM_L    = NUM_LINE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic [1:0]       rd_sel,
  output logic [W-1:0]     rd_data,
  input  logic [NUM_E-1:0] evt_set,
  output logic [NUM_L-1:0] irq
);
  localparam int GS_IDX = GS_BIT - E_LSB;

  logic             srst_n;
  logic [W-1:0]     ev_q;
  logic [W-1:0]     mask_q;
  logic             ev_wr;
  logic             mask_wr;
  logic             gs_req;
  logic [NUM_E-1:0] set_all;

  mic_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign ev_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_EVENT);
  assign mask_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);
  assign gs_req  = wr_en && (reg_sel_e'(wr_sel) == SEL_TXCTL) && wr_data[0];

  always_comb begin
    set_all = evt_set;
    set_all[GS_IDX] = evt_set[GS_IDX] | gs_req;
  end

  mic_event_reg #(.W(W), .NUM_EVT(NUM_E), .EVT_LSB(E_LSB)) u_ev (
    .clk      (clk),
    .rst_n    (srst_n),
    .soft_clr (soft_rst),
    .clr_en   (ev_wr),
    .clr_bits (wr_data),
    .set_vec  (set_all),
    .ev_q     (ev_q)
  );

  mic_mask_reg #(.W(W)) u_mask (
    .clk      (clk),
    .rst_n    (srst_n),
    .soft_clr (soft_rst),
    .load     (mask_wr),
    .load_val (wr_data),
    .mask_q   (mask_q)
  );

  mic_line_fanout #(.W(W), .NUM_LINE(NUM_L)) u_fan (
    .clk   (clk),
    .rst_n (srst_n),
    .ev    (ev_q),
    .mask  (mask_q),
    .irq_q (irq)
  );

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_EVENT: rd_data = ev_q;
      SEL_MASK:  rd_data = mask_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mic_irq_ctrl_chk.sv
module mic_irq_ctrl_chk
  import mic_pkg::*;
(
  input logic        clk,
  input logic        srst_n,
  input logic        soft_rst,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic [12:0] evt_set,
  input logic [31:0] ev_q,
  input logic [31:0] mask_q,
  input logic [12:0] irq
);
  // R9
  soft_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    soft_rst |=> (ev_q == 32'd0 && mask_q == 32'd0));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && wr_sel == 2'd1 && !soft_rst) |=> (mask_q == $past(wr_data)));

  // R8
  gs_set_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && wr_sel == 2'd2 && wr_data[0] && !soft_rst) |=> ev_q[28]);

  // R10
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ev_q[18:0] == 19'd0);

  // R7
  for (genvar k = 0; k < 13; k++) begin : g_evt
    set_wins_chk: assert property (@(posedge clk) disable iff (!srst_n)
      (evt_set[k] && !soft_rst) |=> ev_q[19+k]);
  end

  // R6
  for (genvar n = 0; n < 13; n++) begin : g_line
    localparam int SRC = line_bit(n);
    line_level_chk: assert property (@(posedge clk) disable iff (!srst_n)
      irq[n] == $past(ev_q[SRC] && mask_q[SRC]));
  end
endmodule

bind mic_irq_ctrl mic_irq_ctrl_chk u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .soft_rst (soft_rst),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .evt_set  (evt_set),
  .ev_q     (ev_q),
  .mask_q   (mask_q),
  .irq      (irq)
);

// File: tb/tb_mic_irq_ctrl.sv
`timescale 1ns/1ps
module tb_mic_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic [12:0] evt_set;
  logic [12:0] irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_ev;
  logic [31:0] m_mask;

  localparam int BIT_OF [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  always #4 clk = ~clk;

  mic_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .evt_set(evt_set), .irq(irq)
  );

  function automatic logic [12:0] exp_irq(input logic [31:0] e, input logic [31:0] m);
    logic [12:0] r;
    for (int n = 0; n < 13; n++) r[n] = e[BIT_OF[n]] & m[BIT_OF[n]];
    return r;
  endfunction

  function automatic logic [31:0] pulse_bits(input logic [12:0] p);
    return {p, 19'd0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  // one clock with the given stimulus, then idle; the model is updated by the caller
  task automatic cyc(input logic we, input logic [1:0] sel, input logic [31:0] d,
                     input logic [12:0] p, input logic sr);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; evt_set = p; soft_rst = sr;
    @(negedge clk);
    wr_en = 0; evt_set = '0; soft_rst = 0;
  endtask

  // compare registers now and the lines one clock later
  task automatic check_all(input string req);
    logic [31:0] v;
    read_reg(2'd0, v); chk({req, " event"}, v, m_ev);
    read_reg(2'd1, v); chk({req, " mask"}, v, m_mask);
    @(negedge clk);
    chk({req, " irq"}, {19'd0, irq}, {19'd0, exp_irq(m_ev, m_mask)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; soft_rst = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0; evt_set = 0;
    m_ev = 0; m_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_all("R1");

    // R5/R6 each line alone under full mask; R2 pulse sets bit 19+k
    cyc(1, 2'd1, 32'hFFFF_FFFF, '0, 0); m_mask = 32'hFFFF_FFFF;
    for (int n = 0; n < 13; n++) begin
      cyc(0, 2'd0, 0, 13'd1 << (BIT_OF[n] - 19), 0);
      m_ev = 32'd1 << BIT_OF[n];
      check_all("R2");
      chk("R5 line", {19'd0, irq}, {19'd0, 13'd1 << n});
      repeat (3) @(negedge clk);
      read_reg(2'd0, v); chk("R2 hold", v, m_ev);
      cyc(1, 2'd0, 32'hFFFF_FFFF, '0, 0); m_ev = 0;
      check_all("R3");
    end

    // R6 all events set, single mask bit open
    cyc(0, 2'd0, 0, 13'h1FFF, 0); m_ev = pulse_bits(13'h1FFF);
    for (int n = 0; n < 13; n++) begin
      cyc(1, 2'd1, 32'd1 << BIT_OF[n], '0, 0); m_mask = 32'd1 << BIT_OF[n];
      check_all("R6");
      chk("R5 mask line", {19'd0, irq}, {19'd0, 13'd1 << n});
    end

    // R4 mask walking patterns and full replacement
    for (int i = 0; i < 32; i++) begin
      logic [31:0] p;
      p = (32'h9E37_79B9 * (i + 1)) ^ (32'd1 << i);
      cyc(1, 2'd1, p, '0, 0); m_mask = p;
      check_all("R4");
    end

    // R3 partial clears leave other bits
    for (int i = 0; i < 13; i++) begin
      logic [31:0] c;
      cyc(0, 2'd0, 0, 13'h1FFF, 0); m_ev = pulse_bits(13'h1FFF);
      c = pulse_bits(13'h0A5B ^ (13'd1 << i)) | 32'h0000_FFFF;
      cyc(1, 2'd0, c, '0, 0); m_ev = m_ev & ~c;
      check_all("R3");
    end

    // R7 set wins against clear of the same bit
    cyc(0, 2'd0, 0, 13'h1FFF, 0); m_ev = pulse_bits(13'h1FFF);
    cyc(1, 2'd0, 32'hFFFF_FFFF, 13'h0111, 0); m_ev = pulse_bits(13'h0111);
    check_all("R7");

    // R8 graceful-stop via transmit control
    cyc(1, 2'd0, 32'hFFFF_FFFF, '0, 0); m_ev = 0;
    cyc(1, 2'd2, 32'hFFFF_FFFE, '0, 0);
    check_all("R8 bit0 low");
    cyc(1, 2'd2, 32'h0000_0001, '0, 0); m_ev = 32'h1000_0000;
    check_all("R8 bit0 high");

    // R10 low bits and unused selects
    cyc(0, 2'd0, 0, 13'h1FFF, 0); m_ev = pulse_bits(13'h1FFF);
    read_reg(2'd0, v); chk("R10 low bits", {13'd0, v[18:0]}, 32'd0);
    read_reg(2'd2, v); chk("R10 sel2", v, 32'd0);
    read_reg(2'd3, v); chk("R10 sel3", v, 32'd0);
    cyc(1, 2'd3, 32'hFFFF_FFFF, '0, 0);
    check_all("R10 sel3 write");

    // R9 soft reset against pulses
    cyc(1, 2'd1, 32'hFFFF_FFFF, '0, 0); m_mask = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R9 pre irq", {19'd0, irq}, {19'd0, 13'h1FFF});
    cyc(0, 2'd0, 0, 13'h1FFF, 1); m_ev = 0; m_mask = 0;
    check_all("R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule